// File: doc/BRIEF.md
# Configurable I/O Pad Controller with Input Conditioning

This block holds the control logic for one general-purpose I/O pad. A single 32-bit configuration word decides who owns the pad. The owner can be the register itself, acting as a plain GPIO. It can be one of up to sixteen alternate on-chip functions, chosen by a selector field. In a bypass ("lite") mode, function 1 is wired straight to the pad. The word also sets the drive level, the transmit and receive buffer enables, and how the incoming pad signal is conditioned.

The incoming level first passes through a two-flop synchronizer. It can then pass through a filter whose kind is selectable: a short glitch filter or a long debounce filter. A separate placement field applies the filter to the receive data path, to the edge-detect path, to both or to neither. Every rising or falling edge on the edge-detect path toggles one of sixteen interrupt lines, chosen by a field of the word. The drive-strength, slew and termination fields have no logic in this block. They are stored and exported to the analog pad cell.

Top module: `pad_ctl`

## Requirements
- R1: After reset, the configuration word reads 0x0000_0000 while the pad input is low, all sixteen interrupt lines are 0, and the analog export is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[31:1]`, and the stored bits read back on `cfg_rdata[31:1]` from the next cycle on. Bit 0 of a write is ignored. `cfg_rdata[0]` always returns the conditioned receive-path level.
- R3: With bit 15 set and bit 7 clear, `pad_out` equals bit 1. The direction field [10:8] sets the enables as follows: 0 gives out and in, 1 gives out only, 2 gives in only, and 3 gives neither. The codes 4 to 7 also give neither enable.
- R4: With bits 15 and 7 clear, `pad_out`, `pad_oe` and `pad_ie` come from the function whose index is in [19:16]. This holds when the buffer mode [25:24] is 0.
- R5: In function ownership, buffer mode 1 takes the transmit enable from the function and forces receive off. Mode 2 takes the transmit enable from the function and forces receive on. Mode 3 forces both enables on.
- R6: With bit 7 set, function 1 drives `pad_out`, `pad_oe` and `pad_ie`. The fields [15], [10:8], [19:16], [25:24] and [27:26] then have no effect, and both paths run unfiltered.
- R7: Without filtering, the receive level follows `pad_in` two clock edges after a change. `core_rx` equals that level while `pad_ie` is high and is 0 otherwise.
- R8: With bit 2 at 0, the filter uses the glitch filter. It passes a new level once that level has been sampled on `GLITCH_CYCLES` consecutive clock edges after the synchronizer, and it rejects shorter pulses.
- R9: With bit 2 at 1, the filter uses the debounce filter. It works the same way but with `DEBOUNCE_CYCLES` consecutive samples.
- R10: The placement field [27:26] applies the filter as follows: 0 to neither path, 1 to the edge path only, 2 to the receive path only, and 3 to both paths.
- R11: Each rising or falling edge on the edge path toggles the interrupt line whose index is in [31:28]. An unfiltered edge path toggles the line three clock edges after the `pad_in` change. No other line changes.
- R12: `ana_cfg` packs the stored analog fields, from the top bit down: termination [23:20], P-strength [14:13], N-strength [6:5], P-slew [4:3] and N-slew [12:11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback, bit 0 the receive level |
| pad_in | input | 1 | Raw level from the pad receiver |
| pad_out | output | 1 | Level driven to the pad |
| pad_oe | output | 1 | Transmit buffer enable |
| pad_ie | output | 1 | Receive buffer enable |
| fn_out | input | NFN | Output level of each alternate function |
| fn_oe | input | NFN | Transmit enable requested by each function |
| fn_ie | input | NFN | Receive enable requested by each function |
| core_rx | output | 1 | Conditioned receive level handed to the core |
| irq_lines | output | 16 | Toggle-style interrupt lines |
| ana_cfg | output | 12 | Analog strength, slew and termination fields |

## Verification
The bench builds the block with `GLITCH_CYCLES` = 4 and `DEBOUNCE_CYCLES` = 16, and keeps sixteen functions. The short filter lengths let the bench cover the exact edge of each filter. It applies a pulse one sample short of the limit and a level held just long enough, for both filter kinds, in a few dozen cycles. The lengths also keep the debounce and glitch cases apart: a 10-cycle pulse passes one filter and not the other. That lets the bench time placement and interrupt delays to the cycle, in both the filtered and the unfiltered variants.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;

  // Configuration word view; bit positions are decoded by the pad logic.
  typedef struct packed {
    logic [3:0] irq_sel;    // 31:28
    logic [1:0] flt_where;  // 27:26
    logic [1:0] buf_mode;   // 25:24
    logic [3:0] term;       // 23:20
    logic [3:0] fn_sel;     // 19:16
    logic       own_gpio;   // 15
    logic [1:0] p_drive;    // 14:13
    logic [1:0] n_slew;     // 12:11
    logic [2:0] dir;        // 10:8
    logic       lite;       // 7
    logic [1:0] n_drive;    // 6:5
    logic [1:0] p_slew;     // 4:3
    logic       flt_kind;   // 2
    logic       tx_level;   // 1
    logic       rx_level;   // 0
  } pad_cfg_t;

  typedef enum logic [2:0] {
    DIR_BOTH = 3'd0,
    DIR_OUT  = 3'd1,
    DIR_IN   = 3'd2,
    DIR_OFF  = 3'd3
  } pad_dir_e;

  typedef enum logic [1:0] {
    BUF_FN      = 2'd0,
    BUF_FN_NORX = 2'd1,
    BUF_FN_RX   = 2'd2,
    BUF_ALL_ON  = 2'd3
  } pad_buf_e;

  localparam int SEL_W   = 4;
  localparam int SEL_N   = 1 << SEL_W;
  localparam int ANA_W   = 12;

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pad_filter.sv
module pad_filter #(
  parameter int GLITCH_CYCLES   = 12,
  parameter int DEBOUNCE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic use_debounce,
  output logic dout
);
  localparam int LONGEST = (DEBOUNCE_CYCLES > GLITCH_CYCLES) ? DEBOUNCE_CYCLES : GLITCH_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] G_LAST = CW'(GLITCH_CYCLES - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          lvl_q, lvl_d;
  logic          cnt_en;

  always_comb begin
    limit  = use_debounce ? D_LAST : G_LAST;
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    cnt_en = (din != lvl_q) || (cnt_q != '0);
    if (din == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      lvl_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/pad_owner_mux.sv
module pad_owner_mux
  import pad_ctl_pkg::*;
#(
  parameter int NFN = 16
) (
  input  logic             lite,
  input  logic             own_gpio,
  input  logic             tx_level,
  input  logic [2:0]       dir,
  input  logic [SEL_W-1:0] fn_sel,
  input  logic [1:0]       buf_mode,
  input  logic [NFN-1:0]   fn_out,
  input  logic [NFN-1:0]   fn_oe,
  input  logic [NFN-1:0]   fn_ie,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_ie
);
  logic [SEL_N-1:0] out_w, oe_w, ie_w;

  for (genvar i = 0; i < SEL_N; i++) begin : g_fn
    if (i < NFN) begin : g_live
      assign out_w[i] = fn_out[i];
      assign oe_w[i]  = fn_oe[i];
      assign ie_w[i]  = fn_ie[i];
    end else begin : g_tie
      assign out_w[i] = 1'b0;
      assign oe_w[i]  = 1'b0;
      assign ie_w[i]  = 1'b0;
    end
  end

  logic sel_out, sel_oe, sel_ie;

  always_comb begin
    sel_out = out_w[fn_sel];
    sel_oe  = oe_w[fn_sel];
    sel_ie  = ie_w[fn_sel];
    if (lite) begin
      pad_out = out_w[1];
      pad_oe  = oe_w[1];
      pad_ie  = ie_w[1];
    end else if (own_gpio) begin
      pad_out = tx_level;
      unique case (dir)
        DIR_BOTH: begin pad_oe = 1'b1; pad_ie = 1'b1; end
        DIR_OUT:  begin pad_oe = 1'b1; pad_ie = 1'b0; end
        DIR_IN:   begin pad_oe = 1'b0; pad_ie = 1'b1; end
        default:  begin pad_oe = 1'b0; pad_ie = 1'b0; end
      endcase
    end else begin
      pad_out = sel_out;
      unique case (buf_mode)
        BUF_FN:      begin pad_oe = sel_oe; pad_ie = sel_ie; end
        BUF_FN_NORX: begin pad_oe = sel_oe; pad_ie = 1'b0;   end
        BUF_FN_RX:   begin pad_oe = sel_oe; pad_ie = 1'b1;   end
        default:     begin pad_oe = 1'b1;   pad_ie = 1'b1;   end
      endcase
    end
  end
endmodule

// File: rtl/pad_irq_steer.sv
module pad_irq_steer
  import pad_ctl_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig,
  input  logic [SEL_W-1:0] sel,
  output logic [NIRQ-1:0]  lines
);
  logic            prev_q;
  logic            edge_seen;
  logic [NIRQ-1:0] lines_q, lines_d, hit;

  always_comb begin
    edge_seen = sig ^ prev_q;
    hit       = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (SEL_W'(i) == sel) hit[i] = 1'b1;
    end
    lines_d = lines_q ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lines_q <= '0;
    else if (edge_seen) lines_q <= lines_d;
  end

  assign lines = lines_q;
endmodule

// File: rtl/pad_ctl.sv
module pad_ctl
  import pad_ctl_pkg::*;
#(
  parameter int NFN             = 16,
  parameter int GLITCH_CYCLES   = 12,
  parameter int DEBOUNCE_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_ie,
  input  logic [NFN-1:0]   fn_out,
  input  logic [NFN-1:0]   fn_oe,
  input  logic [NFN-1:0]   fn_ie,
  output logic             core_rx,
  output logic [15:0]      irq_lines,
  output logic [ANA_W-1:0] ana_cfg
);
  localparam int NIRQ = 16;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_loc_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_loc_n = rst_pipe_q[1];

  // configuration storage (bit 0 is not stored)
  logic [31:1] word_q, word_d;
  always_comb begin
    word_d = cfg_we ? cfg_wdata[31:1] : word_q;
  end
  always_ff @(posedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n)  word_q <= '0;
    else if (cfg_we) word_q <= word_d;
  end

  pad_cfg_t cfg;
  logic     rx_sel;
  assign cfg       = pad_cfg_t'({word_q, rx_sel});
  assign cfg_rdata = cfg;

  // input conditioning
  logic pin_sync, pin_filt;
  logic flt_rx, flt_edge, edge_sel;

  pad_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_loc_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  pad_filter #(
    .GLITCH_CYCLES  (GLITCH_CYCLES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_filt (
    .clk         (clk),
    .rst_n       (rst_loc_n),
    .din         (pin_sync),
    .use_debounce(cfg.flt_kind),
    .dout        (pin_filt)
  );

  assign flt_rx   = !cfg.lite && cfg.flt_where[1];
  assign flt_edge = !cfg.lite && cfg.flt_where[0];
  assign rx_sel   = flt_rx   ? pin_filt : pin_sync;
  assign edge_sel = flt_edge ? pin_filt : pin_sync;

  // pad ownership
  pad_owner_mux #(.NFN(NFN)) u_mux (
    .lite    (cfg.lite),
    .own_gpio(cfg.own_gpio),
    .tx_level(cfg.tx_level),
    .dir     (cfg.dir),
    .fn_sel  (cfg.fn_sel),
    .buf_mode(cfg.buf_mode),
    .fn_out  (fn_out),
    .fn_oe   (fn_oe),
    .fn_ie   (fn_ie),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_ie  (pad_ie)
  );

  assign core_rx = rx_sel & pad_ie;

  // interrupt steering
  pad_irq_steer #(.NIRQ(NIRQ)) u_irq (
    .clk  (clk),
    .rst_n(rst_loc_n),
    .sig  (edge_sel),
    .sel  (cfg.irq_sel),
    .lines(irq_lines)
  );

  assign ana_cfg = {cfg.term, cfg.p_drive, cfg.n_drive, cfg.p_slew, cfg.n_slew};
endmodule

// File: rtl/pad_ctl_chk.sv
module pad_ctl_chk #(
  parameter int NFN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             pad_out,
  input logic             pad_oe,
  input logic             pad_ie,
  input logic [NFN-1:0]   fn_out,
  input logic             core_rx,
  input logic [15:0]      irq_lines,
  input logic [11:0]      ana_cfg
);
  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[31:1] == $past(cfg_wdata[31:1]));

  // R3
  dir_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[15] && !cfg_rdata[7] && cfg_rdata[10]) |-> (!pad_oe && !pad_ie));

  // R6
  lite_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] |-> (pad_out == fn_out[1]));

  // R7
  core_rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rx |-> pad_ie);

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines ^ $past(irq_lines)));

  // R12
  ana_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(ana_cfg));
endmodule

bind pad_ctl pad_ctl_chk #(.NFN(NFN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_ie   (pad_ie),
  .fn_out   (fn_out),
  .core_rx  (core_rx),
  .irq_lines(irq_lines),
  .ana_cfg  (ana_cfg)
);

// File: tb/pad_ctl_test.sv
module pad_ctl_test;
  import pad_ctl_pkg::*;

  localparam int NFN = 16;
  localparam int GL  = 4;
  localparam int DB  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic pad_in = 1'b0;
  logic pad_out, pad_oe, pad_ie, core_rx;
  logic [NFN-1:0] fn_out = '0, fn_oe = '0, fn_ie = '0;
  logic [15:0] irq_lines;
  logic [11:0] ana_cfg;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pad_ctl #(.NFN(NFN), .GLITCH_CYCLES(GL), .DEBOUNCE_CYCLES(DB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .fn_out(fn_out), .fn_oe(fn_oe),
    .fn_ie(fn_ie), .core_rx(core_rx), .irq_lines(irq_lines), .ana_cfg(ana_cfg)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input pad_cfg_t v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_pad(input logic v);
    @(negedge clk);
    pad_in = v;
  endtask

  function automatic pad_cfg_t in_cfg(input logic [1:0] where, input logic kind,
                                      input logic [3:0] line);
    pad_cfg_t c = '0;
    c.own_gpio  = 1'b1;
    c.dir       = DIR_IN;
    c.flt_where = where;
    c.flt_kind  = kind;
    c.irq_sel   = line;
    return c;
  endfunction

  task automatic t_reset();
    step(1);
    chk(cfg_rdata == 32'h0, "R1", "cfg after reset", cfg_rdata, 32'h0);
    chk(irq_lines == 16'h0, "R1", "irq after reset", {16'h0, irq_lines}, 32'h0);
    chk(ana_cfg == 12'h0, "R1", "ana after reset", {20'h0, ana_cfg}, 32'h0);
  endtask

  task automatic t_regs();
    pad_cfg_t c;
    c = 32'h5A5A_A5A5;
    wr(c);
    #1;
    chk(cfg_rdata == 32'h5A5A_A5A4, "R2", "readback, bit0 ignored", cfg_rdata, 32'h5A5A_A5A4);
    chk(ana_cfg == {c.term, c.p_drive, c.n_drive, c.p_slew, c.n_slew}, "R12", "analog pack",
        {20'h0, ana_cfg}, {20'h0, c.term, c.p_drive, c.n_drive, c.p_slew, c.n_slew});
    c = 32'hFFFF_FFFF;
    wr(c);
    #1;
    chk(cfg_rdata == 32'hFFFF_FFFE, "R2", "all ones readback", cfg_rdata, 32'hFFFF_FFFE);
    chk(ana_cfg == 12'hFFF, "R12", "analog all ones", {20'h0, ana_cfg}, 32'hFFF);
    wr('0);
  endtask

  task automatic t_gpio();
    pad_cfg_t c = '0;
    c.own_gpio = 1'b1;
    fn_out = '1; fn_oe = '1; fn_ie = '1;
    for (int d = 0; d < 8; d++) begin
      logic eo, ei;
      c.dir = 3'(d);
      c.tx_level = d[0];
      wr(c);
      #1;
      eo = (d == 0 || d == 1);
      ei = (d == 0 || d == 2);
      chk(pad_oe == eo && pad_ie == ei, "R3", "dir enables",
          {30'h0, pad_oe, pad_ie}, {30'h0, eo, ei});
      chk(pad_out == d[0], "R3", "tx level", {31'h0, pad_out}, {31'h0, d[0]});
    end
    fn_out = '0; fn_oe = '0; fn_ie = '0;
    wr('0);
  endtask

  task automatic t_func();
    pad_cfg_t c = '0;
    fn_out = 16'hA5C3; fn_oe = 16'h3C96; fn_ie = 16'hF00F;
    for (int k = 0; k < 16; k += 5) begin
      c.fn_sel = 4'(k);
      c.buf_mode = BUF_FN;
      c.tx_level = ~fn_out[k];
      wr(c);
      #1;
      chk(pad_out == fn_out[k] && pad_oe == fn_oe[k] && pad_ie == fn_ie[k], "R4", "function select",
          {29'h0, pad_out, pad_oe, pad_ie}, {29'h0, fn_out[k], fn_oe[k], fn_ie[k]});
      c.buf_mode = BUF_FN_NORX;
      wr(c); #1;
      chk(pad_oe == fn_oe[k] && !pad_ie, "R5", "mode 1",
          {30'h0, pad_oe, pad_ie}, {30'h0, fn_oe[k], 1'b0});
      c.buf_mode = BUF_FN_RX;
      wr(c); #1;
      chk(pad_oe == fn_oe[k] && pad_ie, "R5", "mode 2",
          {30'h0, pad_oe, pad_ie}, {30'h0, fn_oe[k], 1'b1});
      c.buf_mode = BUF_ALL_ON;
      wr(c); #1;
      chk(pad_oe && pad_ie && pad_out == fn_out[k], "R5", "mode 3",
          {29'h0, pad_out, pad_oe, pad_ie}, {29'h0, fn_out[k], 2'b11});
    end
    fn_out = '0; fn_oe = '0; fn_ie = '0;
    wr('0);
  endtask

  task automatic t_lite();
    pad_cfg_t c = '0;
    c.lite = 1'b1; c.own_gpio = 1'b1; c.dir = DIR_OFF; c.fn_sel = 4'd9;
    c.buf_mode = BUF_ALL_ON; c.flt_where = 2'd3; c.flt_kind = 1'b1; c.tx_level = 1'b1;
    fn_out = 16'h0002; fn_oe = 16'h0000; fn_ie = 16'h0002;
    wr(c);
    #1;
    chk(pad_out == 1'b1 && !pad_oe && pad_ie, "R6", "function 1 owns pad",
        {29'h0, pad_out, pad_oe, pad_ie}, 32'h5);
    fn_out = 16'hFFFD; fn_oe = 16'h0002; fn_ie = 16'hFFFD;
    #1;
    chk(pad_out == 1'b0 && pad_oe && !pad_ie, "R6", "follows function 1 only",
        {29'h0, pad_out, pad_oe, pad_ie}, 32'h2);
    fn_ie = 16'h0002;
    drive_pad(1'b1);
    step(2);
    chk(cfg_rdata[0] == 1'b1, "R6", "filter bypassed in lite", {31'h0, cfg_rdata[0]}, 32'h1);
    drive_pad(1'b0);
    step(DB + 6);
    fn_out = '0; fn_oe = '0; fn_ie = '0;
    wr('0);
    step(DB + 6);
  endtask

  task automatic t_sync();
    wr(in_cfg(2'd0, 1'b0, 4'd0));
    drive_pad(1'b1);
    step(1);
    chk(cfg_rdata[0] == 1'b0, "R7", "one edge, not yet", {31'h0, cfg_rdata[0]}, 32'h0);
    step(1);
    chk(cfg_rdata[0] == 1'b1 && core_rx, "R7", "two edges, visible",
        {30'h0, cfg_rdata[0], core_rx}, 32'h3);
    begin
      pad_cfg_t c = in_cfg(2'd0, 1'b0, 4'd0);
      c.dir = DIR_OUT;
      wr(c); #1;
      chk(cfg_rdata[0] == 1'b1 && !core_rx, "R7", "core_rx gated by receive enable",
          {30'h0, cfg_rdata[0], core_rx}, 32'h2);
    end
    drive_pad(1'b0);
    step(DB + 6);
  endtask

  task automatic t_filter(input logic kind, input int thr, input string req);
    logic [15:0] base;
    int seen;
    wr(in_cfg(2'd3, kind, 4'd2));
    step(DB + 6);
    base = irq_lines;
    drive_pad(1'b1);
    repeat (thr - 1) @(negedge clk);
    pad_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 3 * DB; i++) begin
      step(1);
      if (cfg_rdata[0]) seen++;
    end
    chk(seen == 0, req, "short pulse rejected", seen, 0);
    chk(irq_lines == base, req, "no edge from short pulse", {16'h0, irq_lines}, {16'h0, base});
    drive_pad(1'b1);
    step(thr + 1);
    chk(cfg_rdata[0] == 1'b0, req, "one sample short", {31'h0, cfg_rdata[0]}, 32'h0);
    step(1);
    chk(cfg_rdata[0] == 1'b1, req, "held long enough", {31'h0, cfg_rdata[0]}, 32'h1);
    drive_pad(1'b0);
    step(DB + 6);
  endtask

  task automatic t_glitch_vs_debounce();
    int seen = 0;
    wr(in_cfg(2'd2, 1'b1, 4'd0));
    step(DB + 6);
    drive_pad(1'b1);
    repeat (10) @(negedge clk);
    pad_in = 1'b0;
    for (int i = 0; i < 3 * DB; i++) begin
      step(1);
      if (cfg_rdata[0]) seen++;
    end
    chk(seen == 0, "R9", "10-cycle pulse rejected by debounce", seen, 0);
  endtask

  task automatic t_where();
    logic [15:0] base;
    wr(in_cfg(2'd2, 1'b0, 4'd0));
    step(DB + 6);
    base = irq_lines;
    drive_pad(1'b1);
    step(2);
    chk(irq_lines == base, "R11", "edge not before third edge", {16'h0, irq_lines}, {16'h0, base});
    step(1);
    chk(irq_lines == (base ^ 16'h0001), "R10", "rx-only: edge path raw",
        {16'h0, irq_lines}, {16'h0, base ^ 16'h0001});
    chk(cfg_rdata[0] == 1'b0, "R10", "rx-only: data still filtered", {31'h0, cfg_rdata[0]}, 32'h0);
    step(3);
    chk(cfg_rdata[0] == 1'b1, "R10", "rx-only: data after filter", {31'h0, cfg_rdata[0]}, 32'h1);
    step(DB + 6);
    wr(in_cfg(2'd1, 1'b0, 4'd0));
    step(2);
    base = irq_lines;
    drive_pad(1'b0);
    step(2);
    chk(cfg_rdata[0] == 1'b0, "R10", "edge-only: data raw", {31'h0, cfg_rdata[0]}, 32'h0);
    step(4);
    chk(irq_lines == base, "R10", "edge-only: edge still filtered", {16'h0, irq_lines}, {16'h0, base});
    step(1);
    chk(irq_lines == (base ^ 16'h0001), "R10", "edge-only: edge after filter",
        {16'h0, irq_lines}, {16'h0, base ^ 16'h0001});
    step(DB + 6);
  endtask

  task automatic t_irq(input logic [3:0] line);
    logic [15:0] base, m;
    wr(in_cfg(2'd0, 1'b0, line));
    step(4);
    base = irq_lines;
    m = 16'h1 << line;
    drive_pad(1'b1);
    step(3);
    chk(irq_lines == (base ^ m), "R11", "rising edge toggles line",
        {16'h0, irq_lines}, {16'h0, base ^ m});
    drive_pad(1'b0);
    step(3);
    chk(irq_lines == base, "R11", "falling edge toggles back", {16'h0, irq_lines}, {16'h0, base});
    step(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_regs();
    t_gpio();
    t_func();
    t_lite();
    t_sync();
    t_filter(1'b0, GL, "R8");
    t_filter(1'b1, DB, "R9");
    t_glitch_vs_debounce();
    t_where();
    t_irq(4'd5);
    t_irq(4'd15);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule